// File: doc/BRIEF.md
# USB OUT Endpoint Packet Receive Buffer

This block buffers the data of one non-control OUT endpoint of a USB device. The USB side writes received bytes one at a time. It closes each packet with a single-cycle pulse that marks the packet either good or bad. Only good packets become visible to the CPU or DMA side. That side reads bytes from the oldest packet, sees the byte count of that packet, and releases the packet when it is done. A packet is released by a CPU clear strobe, by a flush strobe, or by hardware once a full maximum-size packet has been read, when the auto-release mode is on.

Packet boundaries are kept in a two-entry length queue. The configured maximum packet size (`cfg_maxp`) sets how many packets can be resident. If twice that size fits in the buffer, two packets can be held back to back. Otherwise only one can be held. While no room is left for another maximum-size packet, the block signals NAK to the USB side.

Top module: `ep_out_fifo`

## Requirements
- R1: After reset, `pkt_ready` is 0, `pkt_len` is 0, `rx_nak` is 0 and `rd_byte` is 0.
- R2: A `rx_good` pulse closes the packet being written. From the next clock edge, `pkt_ready` is 1 and, if no older packet is resident, `pkt_len` equals the number of bytes pushed for that packet. This count includes a push in the same cycle as the pulse.
- R3: A `rx_bad` pulse without `rx_good` discards every byte of the open packet. `pkt_ready` and `pkt_len` are left unchanged, and the next packet starts from an empty write position.
- R4: `rd_byte` shows the oldest unread byte of the oldest resident packet. Each `rd_pop` moves to the next byte, in the order the bytes were pushed.
- R5: A `rd_pop` while `pkt_ready` is 0, or after all `pkt_len` bytes of the oldest packet are read, is ignored, and `rd_byte` reads 0.
- R6: With `cfg_auto_clr`=0, a `cpu_clr` pulse releases the oldest packet and skips any of its unread bytes. With `cfg_auto_clr`=1, `cpu_clr` has no effect.
- R7: With `cfg_auto_clr`=1, the pop that reads byte number `cfg_maxp` of a packet also releases that packet at the same clock edge.
- R8: When 2*`cfg_maxp` is greater than the buffer depth, at most one packet is resident. `rx_nak` is 1 while it is resident, and pushes and `rx_good` pulses are then ignored.
- R9: When 2*`cfg_maxp` is at most the depth, two packets can be resident, and `rx_nak` is 1 only while two are held. Releasing the older packet leaves `pkt_ready` at 1, with `pkt_len` giving the younger packet's length.
- R10: A `cpu_flush` pulse releases exactly the oldest packet in either mode. With one packet resident the buffer becomes empty, and with two only the older packet is dropped.
- R11: Pushes after `cfg_maxp` bytes in one packet are dropped, so a committed length never exceeds `cfg_maxp`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_maxp | input | LW | Maximum packet size in bytes, 1 to DEPTH, static between resets |
| cfg_auto_clr | input | 1 | 1: release a packet after cfg_maxp bytes are popped |
| rx_push | input | 1 | Write one received byte |
| rx_byte | input | DW | Received byte |
| rx_good | input | 1 | Packet ended without error |
| rx_bad | input | 1 | Packet ended with error, discard it |
| rx_nak | output | 1 | No room for another maximum-size packet |
| rd_pop | input | 1 | Consume the byte on rd_byte |
| rd_byte | output | DW | Oldest unread byte, 0 when none |
| pkt_ready | output | 1 | At least one good packet resident |
| pkt_len | output | LW | Byte count of the oldest resident packet |
| cpu_clr | input | 1 | CPU release of the oldest packet (manual mode) |
| cpu_flush | input | 1 | Discard the oldest packet |

## Verification
If the length queue or the read base pointer goes wrong, the effect shows at the ports within one packet. `pkt_len` reports a wrong count right after a release, or `rd_byte` returns the bytes of a neighbouring packet on the first pop after that release. A write pointer that was not rewound after a bad packet shows up at the next good packet: its bytes come out shifted, or stale bytes come out first. The resident-packet count is visible in the same cycle through `pkt_ready` and `rx_nak`. The bench therefore compares all four outputs after every operation, against a byte-level model of the two packet slots.

// File: rtl/ep_out_pkg.sv
// Package: types and helpers shared by the OUT endpoint buffer modules.
// Assumes: callers pass plain byte counts.
package ep_out_pkg;

    // Reason a packet is released from the read side.
    typedef enum logic [1:0] {
        REL_NONE  = 2'd0,
        REL_CPU   = 2'd1,
        REL_FLUSH = 2'd2,
        REL_AUTO  = 2'd3
    } rel_cause_e;

    // True when two maximum-size packets fit in the buffer.
    function automatic logic fits_two(input int unsigned maxp, input int unsigned depth);
        return (maxp * 2) <= depth;
    endfunction

endpackage

// File: rtl/ep_out_store.sv
// Module: byte storage array, one write port and one combinational read port.
// Assumes: DEPTH is a power of two. The contents are not reset, because every
// read is gated by packet state above this module.
module ep_out_store #(
    parameter int DW    = 8,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    // Write one received byte.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Present the addressed byte to the read side.
    assign rdata = mem[raddr];
endmodule

// File: rtl/ep_out_wr_ctrl.sv
// Module: write-side control. It tracks the start of the open packet and its
// length so far, commits the packet on a good end and rewinds on a bad end.
// Assumes: 'room' is stable for the whole packet; a good end wins over a bad end.
module ep_out_wr_ctrl #(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          good,
    input  logic          bad,
    input  logic [LW-1:0] maxp,
    input  logic          room,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic          commit,
    output logic [LW-1:0] commit_len
);
    logic [AW-1:0] base;
    logic [LW-1:0] len;
    logic          take;

    assign take       = push && room && (len < maxp);
    assign we         = take;
    assign waddr      = base + len[AW-1:0];
    assign commit_len = len + LW'(take);
    assign commit     = good && room;

    // Advance the open packet, commit it, or rewind it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base <= '0;
            len  <= '0;
        end else if (commit) begin
            base <= base + commit_len[AW-1:0];
            len  <= '0;
        end else if (good || bad) begin
            len  <= '0;
        end else if (take) begin
            len  <= len + LW'(1);
        end
    end

    assert_len_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
        len <= maxp);
    assert_bad_rewind_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bad && !good) |=> (len == '0) && $stable(base));
endmodule

// File: rtl/ep_out_len_queue.sv
// Module: two-entry queue of committed packet lengths, head = oldest packet.
// Assumes: commit is only raised when a slot will be free after this cycle's release.
module ep_out_len_queue #(
    parameter int LW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          commit,
    input  logic [LW-1:0] commit_len,
    input  logic          release_pkt,
    output logic [LW-1:0] head_len,
    output logic [1:0]    count
);
    logic [LW-1:0] q0, q1, nq0, nq1;
    logic [1:0]    cnt, after_rel;
    logic          rel_ok, com_ok;

    assign rel_ok    = release_pkt && (cnt != 2'd0);
    assign after_rel = cnt - {1'b0, rel_ok};
    assign com_ok    = commit && (after_rel != 2'd2);

    // Work out next entries: shift on release, then append the commit.
    always_comb begin
        nq0 = rel_ok ? q1 : q0;
        nq1 = q1;
        if (com_ok) begin
            if (after_rel == 2'd0) nq0 = commit_len;
            else                   nq1 = commit_len;
        end
    end

    // Register queue entries and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q0  <= '0;
            q1  <= '0;
            cnt <= 2'd0;
        end else begin
            q0  <= nq0;
            q1  <= nq1;
            cnt <= after_rel + {1'b0, com_ok};
        end
    end

    assign head_len = q0;
    assign count    = cnt;

    assert_cnt_max_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt != 2'd3);
    assert_commit_room_R8: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (cnt != 2'd2));
endmodule

// File: rtl/ep_out_rd_ctrl.sv
// Module: read-side control. It walks the oldest packet byte by byte and
// decides when that packet is released (CPU clear, flush or auto release).
// Assumes: head_len and have_pkt come from the length queue head.
module ep_out_rd_ctrl
    import ep_out_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pop,
    input  logic          cpu_clr,
    input  logic          flush,
    input  logic          auto_clr,
    input  logic [LW-1:0] maxp,
    input  logic [LW-1:0] head_len,
    input  logic          have_pkt,
    output logic [AW-1:0] raddr,
    output logic          data_ok,
    output logic          release_pkt
);
    logic [AW-1:0] rd_base;
    logic [LW-1:0] rd_cnt;
    logic          pop_ok;
    rel_cause_e    cause;

    assign data_ok = have_pkt && (rd_cnt < head_len);
    assign pop_ok  = pop && data_ok;
    assign raddr   = rd_base + rd_cnt[AW-1:0];

    // Pick the release cause; flush first, CPU clear only in manual mode.
    always_comb begin
        cause = REL_NONE;
        if (have_pkt) begin
            if (flush)                                            cause = REL_FLUSH;
            else if (cpu_clr && !auto_clr)                        cause = REL_CPU;
            else if (auto_clr && pop_ok && (rd_cnt + LW'(1) == maxp)) cause = REL_AUTO;
        end
    end

    assign release_pkt = (cause != REL_NONE);

    // Step the read position, or jump past the released packet.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_base <= '0;
            rd_cnt  <= '0;
        end else if (release_pkt) begin
            rd_base <= rd_base + head_len[AW-1:0];
            rd_cnt  <= '0;
        end else if (pop_ok) begin
            rd_cnt  <= rd_cnt + LW'(1);
        end
    end

    assert_release_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        release_pkt |=> (rd_cnt == '0));
    assert_cnt_in_pkt_R5: assert property (@(posedge clk) disable iff (!rst_n)
        have_pkt |-> (rd_cnt <= head_len));
endmodule

// File: rtl/ep_out_fifo.sv
// Module: top of the OUT endpoint packet buffer. It joins the storage, the
// write and read control and the length queue, and sets the resident-packet limit.
// Assumes: cfg_maxp is 1..DEPTH and static between resets; DEPTH is a power of two.
module ep_out_fifo
    import ep_out_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [LW-1:0] cfg_maxp,
    input  logic          cfg_auto_clr,
    input  logic          rx_push,
    input  logic [DW-1:0] rx_byte,
    input  logic          rx_good,
    input  logic          rx_bad,
    output logic          rx_nak,
    input  logic          rd_pop,
    output logic [DW-1:0] rd_byte,
    output logic          pkt_ready,
    output logic [LW-1:0] pkt_len,
    input  logic          cpu_clr,
    input  logic          cpu_flush
);
    logic          two_mode, room;
    logic          we, commit, release_pkt, data_ok;
    logic [AW-1:0] waddr, raddr;
    logic [LW-1:0] commit_len, head_len;
    logic [1:0]    count;
    logic [DW-1:0] rdata;

    assign two_mode  = fits_two(32'(cfg_maxp), 32'(DEPTH));
    assign room      = count < (two_mode ? 2'd2 : 2'd1);
    assign rx_nak    = !room;
    assign pkt_ready = (count != 2'd0);
    assign pkt_len   = pkt_ready ? head_len : '0;
    assign rd_byte   = data_ok ? rdata : '0;

    ep_out_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .we    (we),
        .waddr (waddr),
        .wdata (rx_byte),
        .raddr (raddr),
        .rdata (rdata)
    );

    ep_out_wr_ctrl #(.DEPTH(DEPTH)) u_wr (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (rx_push),
        .good       (rx_good),
        .bad        (rx_bad),
        .maxp       (cfg_maxp),
        .room       (room),
        .we         (we),
        .waddr      (waddr),
        .commit     (commit),
        .commit_len (commit_len)
    );

    ep_out_len_queue #(.LW(LW)) u_lenq (
        .clk         (clk),
        .rst_n       (rst_n),
        .commit      (commit),
        .commit_len  (commit_len),
        .release_pkt (release_pkt),
        .head_len    (head_len),
        .count       (count)
    );

    ep_out_rd_ctrl #(.DEPTH(DEPTH)) u_rd (
        .clk         (clk),
        .rst_n       (rst_n),
        .pop         (rd_pop),
        .cpu_clr     (cpu_clr),
        .flush       (cpu_flush),
        .auto_clr    (cfg_auto_clr),
        .maxp        (cfg_maxp),
        .head_len    (head_len),
        .have_pkt    (pkt_ready),
        .raddr       (raddr),
        .data_ok     (data_ok),
        .release_pkt (release_pkt)
    );

    assert_ready_after_good_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pkt_ready) |-> $past(rx_good));
    assert_single_slot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!two_mode && pkt_ready) |-> rx_nak);
    assert_flush_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_flush && (count == 2'd1) && !commit) |=> !pkt_ready);
endmodule

// File: tb/sim_ep_out_fifo.sv
// Bench: directed corner cases followed by seeded random traffic. The outputs
// are compared after every operation with a byte-level model of two packet slots.
module sim_ep_out_fifo;
    localparam int DEPTH = 64;
    localparam int LW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [LW-1:0] cfg_maxp = LW'(16);
    logic          cfg_auto_clr = 1'b0;
    logic          rx_push = 1'b0, rx_good = 1'b0, rx_bad = 1'b0;
    logic [7:0]    rx_byte = 8'h00;
    logic          rx_nak, rd_pop = 1'b0, pkt_ready, cpu_clr = 1'b0, cpu_flush = 1'b0;
    logic [7:0]    rd_byte;
    logic [LW-1:0] pkt_len;

    int compared = 0, mismatched = 0;
    bit done = 0;

    // model state
    logic [7:0] mq [2][64];
    int mlen [2];
    int mcnt, mrd, maxp;
    bit mauto;

    always #2 clk = ~clk;

    ep_out_fifo #(.DW(8), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_maxp(cfg_maxp), .cfg_auto_clr(cfg_auto_clr),
        .rx_push(rx_push), .rx_byte(rx_byte), .rx_good(rx_good), .rx_bad(rx_bad),
        .rx_nak(rx_nak), .rd_pop(rd_pop), .rd_byte(rd_byte), .pkt_ready(pkt_ready),
        .pkt_len(pkt_len), .cpu_clr(cpu_clr), .cpu_flush(cpu_flush)
    );

    function automatic int slots();
        return (2 * maxp <= DEPTH) ? 2 : 1;
    endfunction

    function automatic int exp_byte();
        return (mcnt > 0 && mrd < mlen[0]) ? int'(mq[0][mrd]) : 0;
    endfunction

    function automatic int exp_len();
        return (mcnt > 0) ? mlen[0] : 0;
    endfunction

    task automatic model_release();
        if (mcnt == 0) return;
        mq[0] = mq[1];
        mlen[0] = mlen[1];
        mcnt--;
        mrd = 0;
    endtask

    task automatic check(string req, string what, int got, int exp);
        compared++;
        if (got != exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic check_all(string req);
        check(req, "pkt_ready", int'(pkt_ready), (mcnt > 0) ? 1 : 0);
        check(req, "pkt_len", int'(pkt_len), exp_len());
        check(req, "rx_nak", int'(rx_nak), (mcnt >= slots()) ? 1 : 0);
        check(req, "rd_byte", int'(rd_byte), exp_byte());
    endtask

    task automatic do_reset(int mp, bit au);
        @(negedge clk);
        rst_n = 1'b0;
        cfg_maxp = LW'(mp);
        cfg_auto_clr = au;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        maxp = mp; mauto = au; mcnt = 0; mrd = 0;
        check_all("R1");
    endtask

    task automatic send_pkt(int len, bit good, bit merge, string req);
        logic [7:0] tmp [64];
        bit acc = (mcnt < slots());
        int n = 0;
        bit mg = merge && (len > 0);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            rx_push = 1'b1;
            rx_byte = 8'($urandom);
            rx_good = mg && (i == len - 1) && good;
            rx_bad  = mg && (i == len - 1) && !good;
            if (acc && i < maxp) begin
                tmp[n] = rx_byte;
                n++;
            end
        end
        if (!mg) begin
            @(negedge clk);
            rx_push = 1'b0;
            rx_good = good;
            rx_bad  = !good;
        end
        @(negedge clk);
        rx_push = 1'b0; rx_good = 1'b0; rx_bad = 1'b0;
        if (good && acc) begin
            mq[mcnt] = tmp;
            mlen[mcnt] = n;
            mcnt++;
        end
        check_all(req);
    endtask

    task automatic pop_one(string req);
        @(negedge clk);
        check(req, "rd_byte before pop", int'(rd_byte), exp_byte());
        rd_pop = 1'b1;
        @(negedge clk);
        rd_pop = 1'b0;
        if (mcnt > 0 && mrd < mlen[0]) begin
            mrd++;
            if (mauto && mrd == maxp) model_release();
        end
        check_all(req);
    endtask

    task automatic pulse_clr(string req);
        @(negedge clk);
        cpu_clr = 1'b1;
        @(negedge clk);
        cpu_clr = 1'b0;
        if (!mauto) model_release();
        check_all(req);
    endtask

    task automatic pulse_flush(string req);
        @(negedge clk);
        cpu_flush = 1'b1;
        @(negedge clk);
        cpu_flush = 1'b0;
        model_release();
        check_all(req);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        int seed_dummy;
        int mps [4];
        seed_dummy = $urandom(32'd2024);
        mps[0] = 16; mps[1] = 32; mps[2] = 40; mps[3] = 8;

        // R1 reset, R2 commit with same-cycle push, R4 ordered pops, R5 overrun
        do_reset(16, 0);
        send_pkt(5, 1, 1, "R2");
        pop_one("R4"); pop_one("R4"); pop_one("R4"); pop_one("R4"); pop_one("R4");
        pop_one("R5");
        pulse_clr("R6");
        pop_one("R5");
        // R3 bad packet discarded, next packet clean
        send_pkt(7, 0, 0, "R3");
        send_pkt(4, 1, 0, "R3");
        pop_one("R3");
        pulse_clr("R6");
        // R9 two resident, third refused, release keeps ready
        send_pkt(16, 1, 0, "R9");
        send_pkt(10, 1, 1, "R9");
        send_pkt(3, 1, 0, "R9");
        pop_one("R6");
        pulse_clr("R9");
        pulse_flush("R10");
        // R11 overlength
        send_pkt(20, 1, 0, "R11");
        for (int i = 0; i < 16; i++) pop_one("R11");
        pulse_clr("R6");
        // R7 auto release, R6 clr ignored in auto, R10 flush of short packet
        do_reset(8, 1);
        send_pkt(8, 1, 0, "R7");
        send_pkt(8, 1, 0, "R7");
        for (int i = 0; i < 8; i++) pop_one("R7");
        pulse_clr("R6");
        for (int i = 0; i < 8; i++) pop_one("R7");
        send_pkt(3, 1, 0, "R7");
        for (int i = 0; i < 3; i++) pop_one("R7");
        pulse_flush("R10");
        // R8 single slot
        do_reset(40, 0);
        send_pkt(40, 1, 0, "R8");
        send_pkt(5, 1, 0, "R8");
        pulse_clr("R8");
        pop_one("R5");

        // random traffic per configuration
        for (int c = 0; c < 4; c++) begin
            do_reset(mps[c], c[0]);
            for (int k = 0; k < 120; k++) begin
                int op = int'($urandom % 10);
                if (op < 4) begin
                    send_pkt(int'($urandom % (maxp + 3)), ($urandom % 5) != 0,
                             ($urandom % 2) != 0, "R4");
                end else if (op < 7) begin
                    int nb = 1 + int'($urandom % maxp);
                    for (int j = 0; j < nb; j++) pop_one("R4");
                end else if (op == 7) begin
                    pulse_clr("R6");
                end else if (op == 8) begin
                    pulse_flush("R10");
                end else begin
                    pop_one("R5");
                end
            end
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule